// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block decides, each cycle, whether an in-order dual-issue integer/floating-point core may send its two oldest decoded instructions together or only the older one. It receives a class code and a valid bit for the older instruction and for the younger one. It also receives a single `block_second` input that gathers every reason decided elsewhere (register dependencies, busy iterative units) for holding the younger instruction back. The logic is purely combinational.

A bundle is legal only when the older instruction is an integer arithmetic, load or store operation, and the younger one is an arithmetic, integer multiply/divide, HI/LO move, branch or floating-point operation. The older slot always drives the memory-side (M-pipe) adder/address generator. The younger slot always takes one of the mutually exclusive F-pipe units. A branch closes the issue group. Unknown, multi-step, atomic and sync-loop classes occupy both issue slots. For each issued instruction, the block reports the execution unit it claims and which adder, if any, it uses.

Top module: `pair_issue_check`

## Requirements
- R1: `issue_first` equals `first_valid`, and `issue_second` is never 1 while `issue_first` is 0.
- R2: Class codes are: 0 arithmetic, 1 load, 2 store, 3 integer multiply, 4 integer divide, 5 HI/LO move, 6 FP-coprocessor move, 7 branch, 8 FP add/convert/compare, 9 FP multiply, 10 FP divide/sqrt, and 11 to 15 issue-alone classes. `issue_second` is 1 exactly when all of the following hold: both instructions are valid; `block_second` is 0; the older class is 0, 1, 2 or 6; the younger class is 0 or 3 to 10; and the two claimed units do not clash.
- R3: A branch (class 7) in the older slot always issues alone.
- R4: A class of 11 to 15 in either slot prevents pairing.
- R5: When `block_second` is 1, `issue_second` is 0 regardless of the classes.
- R6: Unit codes are 0 none, 1 M-pipe adder/address generator, 2 F-pipe integer adder, 3 branch, 4 integer multiply/divide, 5 FP add, 6 FP multiply, 7 FP divide/sqrt. For an issued older instruction, `first_unit` is 1 for classes 0, 1, 2 and 6; 4 for classes 3 to 5; 3 for class 7; 5, 6 or 7 for classes 8, 9 or 10; and 0 for classes 11 to 15.
- R7: For an issued younger instruction, `second_unit` is 2 for classes 0 and 6, and follows the R6 mapping for classes 3 to 10.
- R8: The adder code of a slot is 1 when its unit is 1, 2 when its unit is 2, and 0 otherwise.
- R9: No two issued instructions claim F-pipe units (codes 2 to 7) in the same cycle, and no two claim the M-pipe unit.
- R10: A slot that does not issue reports unit 0 and adder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| first_valid | input | 1 | Older instruction present |
| first_class | input | 4 | Older instruction class code |
| second_valid | input | 1 | Younger instruction present |
| second_class | input | 4 | Younger instruction class code |
| block_second | input | 1 | External hold on the younger instruction |
| issue_first | output | 1 | Older instruction issues this cycle |
| issue_second | output | 1 | Younger instruction issues with it |
| first_unit | output | 3 | Unit claimed by the older instruction |
| second_unit | output | 3 | Unit claimed by the younger instruction |
| first_adder | output | 2 | Adder used by the older instruction |
| second_adder | output | 2 | Adder used by the younger instruction |

## Verification
Whenever the inputs settle, the assertions check several properties: the younger slot never issues alone, the external hold always wins, a branch in the older slot never carries a partner, at most one F-pipe unit is claimed, and each adder code agrees with its unit code. The exact pairing decision and unit mapping for every class pair can only be shown by the bench. It sweeps all class combinations with every setting of the valid and hold bits and compares the results with an independently computed table.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int CLASS_W = 4;
  localparam int UNIT_W  = 3;
  localparam int ADDER_W = 2;
  localparam int NUM_UNITS = 1 << UNIT_W;

  localparam logic [CLASS_W-1:0] CL_ARITH  = 4'd0;
  localparam logic [CLASS_W-1:0] CL_LOAD   = 4'd1;
  localparam logic [CLASS_W-1:0] CL_STORE  = 4'd2;
  localparam logic [CLASS_W-1:0] CL_IMUL   = 4'd3;
  localparam logic [CLASS_W-1:0] CL_IDIV   = 4'd4;
  localparam logic [CLASS_W-1:0] CL_HILO   = 4'd5;
  localparam logic [CLASS_W-1:0] CL_FPXFER = 4'd6;
  localparam logic [CLASS_W-1:0] CL_BRANCH = 4'd7;
  localparam logic [CLASS_W-1:0] CL_FPADD  = 4'd8;
  localparam logic [CLASS_W-1:0] CL_FPMUL  = 4'd9;
  localparam logic [CLASS_W-1:0] CL_FPDIV  = 4'd10;
  localparam logic [CLASS_W-1:0] CL_SOLO   = 4'd11;

  localparam logic [UNIT_W-1:0] U_NONE   = 3'd0;
  localparam logic [UNIT_W-1:0] U_MADD   = 3'd1;
  localparam logic [UNIT_W-1:0] U_FADD   = 3'd2;
  localparam logic [UNIT_W-1:0] U_BRANCH = 3'd3;
  localparam logic [UNIT_W-1:0] U_IMD    = 3'd4;
  localparam logic [UNIT_W-1:0] U_FPADD  = 3'd5;
  localparam logic [UNIT_W-1:0] U_FPMUL  = 3'd6;
  localparam logic [UNIT_W-1:0] U_FPDIV  = 3'd7;

  localparam logic [ADDER_W-1:0] ADD_NONE = 2'd0;
  localparam logic [ADDER_W-1:0] ADD_M    = 2'd1;
  localparam logic [ADDER_W-1:0] ADD_F    = 2'd2;

  function automatic logic class_is_solo(input logic [CLASS_W-1:0] c);
    return c >= CL_SOLO;
  endfunction

  function automatic logic class_int_arith(input logic [CLASS_W-1:0] c);
    return (c == CL_ARITH) || (c == CL_FPXFER);
  endfunction

  function automatic logic class_fits_older(input logic [CLASS_W-1:0] c);
    return class_int_arith(c) || (c == CL_LOAD) || (c == CL_STORE);
  endfunction

  function automatic logic class_fits_younger(input logic [CLASS_W-1:0] c);
    return class_int_arith(c) || ((c >= CL_IMUL) && (c <= CL_FPDIV) && (c != CL_FPXFER));
  endfunction

  function automatic logic [UNIT_W-1:0] class_unit(input logic [CLASS_W-1:0] c,
                                                   input logic young);
    logic [UNIT_W-1:0] u;
    case (c)
      CL_ARITH, CL_FPXFER:      u = young ? U_FADD : U_MADD;
      CL_LOAD, CL_STORE:        u = U_MADD;
      CL_IMUL, CL_IDIV, CL_HILO: u = U_IMD;
      CL_BRANCH:                u = U_BRANCH;
      CL_FPADD:                 u = U_FPADD;
      CL_FPMUL:                 u = U_FPMUL;
      CL_FPDIV:                 u = U_FPDIV;
      default:                  u = U_NONE;
    endcase
    return u;
  endfunction

  function automatic logic unit_on_fpipe(input logic [UNIT_W-1:0] u);
    return u >= U_FADD;
  endfunction

  function automatic logic [ADDER_W-1:0] unit_adder(input logic [UNIT_W-1:0] u);
    logic [ADDER_W-1:0] a;
    if (u == U_MADD)      a = ADD_M;
    else if (u == U_FADD) a = ADD_F;
    else                  a = ADD_NONE;
    return a;
  endfunction
endpackage

// File: rtl/pair_slot_decode.sv
module pair_slot_decode
  import pair_pkg::*;
#(
  parameter bit YOUNG = 1'b0
) (
  input  logic [CLASS_W-1:0] cls,
  output logic [UNIT_W-1:0]  unit,
  output logic               shape_ok,
  output logic               solo
);
  always_comb begin
    unit     = class_unit(cls, YOUNG);
    solo     = class_is_solo(cls);
    shape_ok = YOUNG ? class_fits_younger(cls) : class_fits_older(cls);
  end

  always_comb begin
    if (solo) begin
      a_r4_solo_no_unit: assert (unit == U_NONE && !shape_ok)
        else $error("solo class claims a unit or a bundle shape");
    end
  end
endmodule

// File: rtl/pair_conflict.sv
module pair_conflict
  import pair_pkg::*;
(
  input  logic [UNIT_W-1:0] unit_a,
  input  logic [UNIT_W-1:0] unit_b,
  output logic              clash
);
  logic both_fpipe;
  logic both_mpipe;

  always_comb begin
    both_fpipe = unit_on_fpipe(unit_a) && unit_on_fpipe(unit_b);
    both_mpipe = (unit_a == U_MADD) && (unit_b == U_MADD);
    clash      = both_fpipe || both_mpipe;
  end

  always_comb begin
    if (unit_a != U_NONE && unit_a == unit_b) begin
      a_r9_same_unit_clash: assert (clash)
        else $error("identical unit claims not flagged");
    end
  end
endmodule

// File: rtl/pair_issue_check.sv
module pair_issue_check
  import pair_pkg::*;
(
  input  logic               first_valid,
  input  logic [CLASS_W-1:0] first_class,
  input  logic               second_valid,
  input  logic [CLASS_W-1:0] second_class,
  input  logic               block_second,
  output logic               issue_first,
  output logic               issue_second,
  output logic [UNIT_W-1:0]  first_unit,
  output logic [UNIT_W-1:0]  second_unit,
  output logic [ADDER_W-1:0] first_adder,
  output logic [ADDER_W-1:0] second_adder
);
  localparam int SLOTS = 2;

  logic [CLASS_W-1:0] slot_cls   [SLOTS];
  logic [UNIT_W-1:0]  slot_unit  [SLOTS];
  logic               slot_shape [SLOTS];
  logic               slot_solo  [SLOTS];

  assign slot_cls[0] = first_class;
  assign slot_cls[1] = second_class;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    pair_slot_decode #(.YOUNG(s == 1)) dec_i (
      .cls      (slot_cls[s]),
      .unit     (slot_unit[s]),
      .shape_ok (slot_shape[s]),
      .solo     (slot_solo[s])
    );
  end

  logic unit_clash;
  pair_conflict conf_i (
    .unit_a (slot_unit[0]),
    .unit_b (slot_unit[1]),
    .clash  (unit_clash)
  );

  logic branch_closes;
  logic any_solo;
  logic shape_legal;
  logic pair_ok;

  always_comb begin
    branch_closes = (slot_unit[0] == U_BRANCH);
    any_solo      = slot_solo[0] || slot_solo[1];
    shape_legal   = slot_shape[0] && slot_shape[1];
    pair_ok       = shape_legal && !any_solo && !unit_clash && !branch_closes;
    issue_first   = first_valid;
    issue_second  = first_valid && second_valid && !block_second && pair_ok;
    first_unit    = issue_first  ? slot_unit[0] : U_NONE;
    second_unit   = issue_second ? slot_unit[1] : U_NONE;
    first_adder   = unit_adder(first_unit);
    second_adder  = unit_adder(second_unit);
  end

  logic [NUM_UNITS-1:0] fpipe_claims;
  always_comb begin
    fpipe_claims = '0;
    if (unit_on_fpipe(first_unit))  fpipe_claims[first_unit]  = 1'b1;
    if (unit_on_fpipe(second_unit)) fpipe_claims[second_unit] = 1'b1;
  end

  always_comb begin
    if (issue_second) begin
      a_r1_second_needs_first: assert (issue_first)
        else $error("younger slot issued alone");
      a_r9_one_fpipe_unit: assert ($countones(fpipe_claims) == 1)
        else $error("F-pipe over-claimed");
      a_r9_one_mpipe: assert (!(first_unit == U_MADD && second_unit == U_MADD))
        else $error("M-pipe claimed twice");
    end
    if (block_second) begin
      a_r5_hold_wins: assert (!issue_second)
        else $error("hold ignored");
    end
    if (first_unit == U_BRANCH) begin
      a_r3_branch_alone: assert (!issue_second)
        else $error("instruction issued after branch");
    end
    a_r8_adder_tracks_unit: assert ((first_adder == ADD_M) == (first_unit == U_MADD)
                                    && (second_adder == ADD_F) == (second_unit == U_FADD))
      else $error("adder code disagrees with unit");
    if (!issue_second) begin
      a_r10_idle_slot_quiet: assert (second_unit == U_NONE && second_adder == ADD_NONE)
        else $error("idle younger slot reports a claim");
    end
  end
endmodule

// File: tb/pair_issue_check_tb_top.sv
module pair_issue_check_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       first_valid  = 1'b0;
  logic [3:0] first_class  = 4'd0;
  logic       second_valid = 1'b0;
  logic [3:0] second_class = 4'd0;
  logic       block_second = 1'b0;
  logic       issue_first, issue_second;
  logic [2:0] first_unit, second_unit;
  logic [1:0] first_adder, second_adder;

  pair_issue_check dut_i (
    .first_valid, .first_class, .second_valid, .second_class, .block_second,
    .issue_first, .issue_second, .first_unit, .second_unit,
    .first_adder, .second_adder
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (v0=%0d c0=%0d v1=%0d c1=%0d blk=%0d)",
               req, act, exp, first_valid, first_class, second_valid,
               second_class, block_second);
    end
  endtask

  // Unit number per the unit table; young selects the arithmetic adder side.
  function automatic int ref_unit(input int c, input bit young);
    if (c == 0 || c == 6) return young ? 2 : 1;
    if (c == 1 || c == 2) return 1;
    if (c >= 3 && c <= 5) return 4;
    if (c == 7) return 3;
    if (c >= 8 && c <= 10) return c - 3;
    return 0;
  endfunction

  function automatic int ref_adder(input int u);
    return (u == 1 || u == 2) ? u : 0;
  endfunction

  function automatic bit ref_pair(input int c0, input int c1);
    bit old_ok, young_ok, fp0, fp1;
    old_ok   = (c0 <= 2) || (c0 == 6);
    young_ok = (c1 == 0) || (c1 >= 3 && c1 <= 10);
    fp0 = ref_unit(c0, 0) >= 2;
    fp1 = ref_unit(c1, 1) >= 2;
    return old_ok && young_ok && !(fp0 && fp1) &&
           !(ref_unit(c0, 0) == 1 && ref_unit(c1, 1) == 1);
  endfunction

  initial begin
    // Reset/idle state: nothing valid.
    @(negedge clk);
    check("R1 idle issue_first", int'(issue_first), 0);
    check("R10 idle second_unit", int'(second_unit), 0);

    for (int mode = 0; mode < 8; mode++) begin
      for (int c0 = 0; c0 < 16; c0++) begin
        for (int c1 = 0; c1 < 16; c1++) begin
          bit v0, v1, blk, pair;
          int u0, u1;
          v0  = mode[0];
          v1  = mode[1];
          blk = mode[2];
          @(posedge clk);
          first_valid  = v0;
          second_valid = v1;
          block_second = blk;
          first_class  = 4'(c0);
          second_class = 4'(c1);
          @(negedge clk);
          pair = v0 && v1 && !blk && ref_pair(c0, c1);
          u0 = v0 ? ref_unit(c0, 0) : 0;
          u1 = pair ? ref_unit(c1, 1) : 0;
          check("R1 issue_first", int'(issue_first), int'(v0));
          if (blk)
            check("R5 hold", int'(issue_second), 0);
          else if (c0 == 7)
            check("R3 branch alone", int'(issue_second), 0);
          else if (c0 >= 11 || c1 >= 11)
            check("R4 solo", int'(issue_second), 0);
          else
            check("R2 pairing", int'(issue_second), int'(pair));
          check("R6 first_unit", int'(first_unit), u0);
          if (pair)
            check("R7 second_unit", int'(second_unit), u1);
          else
            check("R10 idle second_unit", int'(second_unit), 0);
          check("R8 first_adder", int'(first_adder), ref_adder(u0));
          check("R8 second_adder", int'(second_adder), ref_adder(u1));
          check("R9 fpipe claims", int'((u0 >= 2) && (u1 >= 2)), 0);
        end
      end
    end

    // Directed corners.
    @(posedge clk);
    first_valid = 1; second_valid = 1; block_second = 0;
    first_class = 4'd0; second_class = 4'd0;
    @(negedge clk);
    check("R8 arith pair M side", int'(first_adder), 1);
    check("R8 arith pair F side", int'(second_adder), 2);
    @(posedge clk);
    first_class = 4'd1; second_class = 4'd2;
    @(negedge clk);
    check("R9 two memory ops", int'(issue_second), 0);
    @(posedge clk);
    first_valid = 0; second_valid = 1; first_class = 4'd0; second_class = 4'd0;
    @(negedge clk);
    check("R1 invalid older blocks younger", int'(issue_second), 0);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule